// File: doc/BRIEF.md
# Word-Window Transfer Buffer

This block is a 512-byte staging store that sits between a host register port and a serial sequencer. The host never sees the store as a memory range. It first writes a control word, which sets the access direction, switches automatic pointer advance on or off and loads a word pointer. After that it moves 32-bit words through a single data window. The window always shows the word under the pointer.

The sequencer works on single bytes. It loads a starting byte offset, which is usually zero before each transaction. It then reads bytes out for transmission and writes received bytes in, one byte per strobe. While the sequencer's transaction is active it owns the store. Any host data access in that time is held off with a stall and has no effect.

Top module: `xfer_word_window`

## Requirements
- R1: After reset every byte of the store is zero, the word pointer and the byte pointer are zero, the direction is host-read and automatic advance is off.
- R2: A control write loads the direction from bit 31 (1 = host writes the store, 0 = host reads it), automatic advance from bit 30 and the word pointer from bits 7:0 taken modulo 128. Any data access in the same cycle is dropped.
- R3: In host-write direction, a data write that is not stalled stores the 32-bit word at the word pointer. The result is visible from the next cycle.
- R4: `host_data_rdata` always shows the word at the word pointer. In host-read direction, a read strobe that is not stalled counts as an access.
- R5: With automatic advance on, each accepted access moves the word pointer up by one, and it wraps from 127 to 0.
- R6: With automatic advance off, accepted accesses leave the word pointer where it is, so they keep reaching the same word.
- R7: A data write while the direction is host-read changes nothing. A read strobe while the direction is host-write does not move the pointer.
- R8: A start-offset write loads the 9-bit byte pointer. It takes precedence over sequencer strobes in the same cycle, and those strobes are dropped.
- R9: Bytes are little-endian within a word. Byte offset b is bits 8*(b mod 4)+7 down to 8*(b mod 4) of word b/4. `seq_rdata` always shows the byte at the byte pointer.
- R10: While `seq_active` is high, `seq_wr` stores `seq_wdata` at the byte pointer and advances it, and `seq_rd` advances it. The byte pointer wraps from 511 to 0. Strobes while `seq_active` is low are ignored.
- R11: A host data strobe while `seq_active` is high raises `host_stall` in the same cycle. That access changes neither the store nor the word pointer.
- R12: When a sequencer write run ends partway through a word, only the low-order bytes of that word take the new payload. Its upper bytes keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ctrl_we | input | 1 | Control word write strobe |
| host_ctrl_wdata | input | 32 | Control word: direction, auto-advance, word pointer |
| host_data_we | input | 1 | Data window write strobe |
| host_data_wdata | input | 32 | Word written through the window |
| host_data_re | input | 1 | Data window read strobe |
| host_data_rdata | output | 32 | Word at the current word pointer |
| host_stall | output | 1 | Host data access refused this cycle |
| seq_active | input | 1 | Sequencer transaction in progress |
| seq_off_we | input | 1 | Start byte offset write strobe |
| seq_off | input | 9 | Start byte offset |
| seq_rd | input | 1 | Consume one byte for transmission |
| seq_wr | input | 1 | Store one received byte |
| seq_wdata | input | 8 | Received byte |
| seq_rdata | output | 8 | Byte at the byte pointer |

## Verification
The assertions check the pointer rules on every cycle. A stalled host access never moves the word pointer. The word pointer stays put when automatic advance is off or the direction does not match the strobe. Both pointers wrap at their ends, and the byte pointer stays still outside a transaction. What was actually stored only shows in the bench scenarios. These cover the little-endian byte placement, the partially filled last word and the writes dropped during a stall or in the wrong direction. The bench compares the data seen through both ports against a byte-level model of the store.

// File: rtl/xfer_window_pkg.sv
// Package: shared constants for the word-window transfer buffer.
// Assumes a little-endian byte order inside each host word.
package xfer_window_pkg;
    localparam int CTRL_DIR_BIT  = 31;   // 1 = host writes the store
    localparam int CTRL_AINC_BIT = 30;   // 1 = pointer advances per access
    localparam int DEF_BYTES     = 512;
    localparam int DEF_LANES     = 4;

    typedef enum logic {
        DIR_HOST_RD = 1'b0,
        DIR_HOST_WR = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/xfer_host_port.sv
// Module: host-side control state and word pointer.
// Holds the direction, the auto-advance flag and the word pointer. It
// decides whether a data strobe is accepted. Assumes the sequencer owns
// the store whenever seq_active is high.
module xfer_host_port
    import xfer_window_pkg::*;
#(
    parameter int WPTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [31:0]       ctrl_wdata,
    input  logic              data_we,
    input  logic              data_re,
    input  logic              seq_active,
    output xfer_dir_e         dir,
    output logic              autoinc,
    output logic [WPTR_W-1:0] wptr,
    output logic              stall,
    output logic              word_store
);
    logic take;
    logic unused_ctrl_bits;

    // Bits of the control word that carry no meaning here
    assign unused_ctrl_bits = ^ctrl_wdata[CTRL_AINC_BIT-1:WPTR_W];

    // Refuse host data strobes while the sequencer owns the store
    assign stall = seq_active & (data_re | data_we);

    // An access counts only when its strobe matches the direction
    always_comb begin
        take = 1'b0;
        if (!ctrl_we && !stall)
            take = (dir == DIR_HOST_WR) ? data_we : data_re;
    end

    assign word_store = take && (dir == DIR_HOST_WR);

    // Control register load and pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= DIR_HOST_RD;
            autoinc <= 1'b0;
            wptr    <= '0;
        end else if (ctrl_we) begin
            dir     <= xfer_dir_e'(ctrl_wdata[CTRL_DIR_BIT]);
            autoinc <= ctrl_wdata[CTRL_AINC_BIT];
            wptr    <= ctrl_wdata[WPTR_W-1:0];
        end else if (take && autoinc) begin
            wptr    <= wptr + 1'b1;
        end
    end
endmodule

// File: rtl/xfer_seq_port.sv
// Module: sequencer-side byte pointer.
// Loads a start offset and advances one byte per strobe while a
// transaction is active. Assumes an offset load outranks the strobes.
module xfer_seq_port #(
    parameter int BPTR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              off_we,
    input  logic [BPTR_W-1:0] off,
    input  logic              active,
    input  logic              rd,
    input  logic              wr,
    output logic [BPTR_W-1:0] bptr,
    output logic              byte_store
);
    logic step;

    // A strobe counts only inside a transaction and without an offset load
    assign step       = active && (rd || wr) && !off_we;
    assign byte_store = step && wr;

    // Byte pointer load and wrap-around advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            bptr <= '0;
        else if (off_we)
            bptr <= off;
        else if (step)
            bptr <= bptr + 1'b1;
    end
endmodule

// File: rtl/xfer_byte_lane.sv
// Module: one byte lane of the store, with a word-wide port and a byte port.
// Both read ports are combinational. A sequencer write outranks a host
// write to the same lane. Cleared by reset.
module xfer_byte_lane #(
    parameter int WORDS  = 128,
    parameter int WPTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WPTR_W-1:0] host_addr,
    input  logic [7:0]        host_byte,
    input  logic              seq_we,
    input  logic [WPTR_W-1:0] seq_addr,
    input  logic [7:0]        seq_byte,
    output logic [7:0]        host_q,
    output logic [7:0]        seq_q
);
    logic [7:0] mem [WORDS];

    // Clear on reset, otherwise store the winning write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '0;
        end else if (seq_we) begin
            mem[seq_addr] <= seq_byte;
        end else if (host_we) begin
            mem[host_addr] <= host_byte;
        end
    end

    assign host_q = mem[host_addr];
    assign seq_q  = mem[seq_addr];
endmodule

// File: rtl/xfer_word_window.sv
// Module: top of the word-window transfer buffer.
// The host reaches the store through one control word and one 32-bit
// window. The sequencer reaches it one byte at a time. Assumes BUF_BYTES
// is a power of two and a multiple of LANES.
module xfer_word_window
    import xfer_window_pkg::*;
#(
    parameter  int BUF_BYTES = DEF_BYTES,
    parameter  int LANES     = DEF_LANES,
    localparam int WORDS     = BUF_BYTES / LANES,
    localparam int WPTR_W    = $clog2(WORDS),
    localparam int BPTR_W    = $clog2(BUF_BYTES),
    localparam int LANE_W    = $clog2(LANES),
    localparam int DATA_W    = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ctrl_we,
    input  logic [31:0]       host_ctrl_wdata,
    input  logic              host_data_we,
    input  logic [DATA_W-1:0] host_data_wdata,
    input  logic              host_data_re,
    output logic [DATA_W-1:0] host_data_rdata,
    output logic              host_stall,
    input  logic              seq_active,
    input  logic              seq_off_we,
    input  logic [BPTR_W-1:0] seq_off,
    input  logic              seq_rd,
    input  logic              seq_wr,
    input  logic [7:0]        seq_wdata,
    output logic [7:0]        seq_rdata
);
    xfer_dir_e         dir;
    logic              autoinc;
    logic [WPTR_W-1:0] wptr;
    logic [BPTR_W-1:0] bptr;
    logic              word_store;
    logic              byte_store;
    logic [7:0]        lane_seq_q [LANES];

    xfer_host_port #(.WPTR_W(WPTR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (host_ctrl_we),
        .ctrl_wdata (host_ctrl_wdata),
        .data_we    (host_data_we),
        .data_re    (host_data_re),
        .seq_active (seq_active),
        .dir        (dir),
        .autoinc    (autoinc),
        .wptr       (wptr),
        .stall      (host_stall),
        .word_store (word_store)
    );

    xfer_seq_port #(.BPTR_W(BPTR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_we     (seq_off_we),
        .off        (seq_off),
        .active     (seq_active),
        .rd         (seq_rd),
        .wr         (seq_wr),
        .bptr       (bptr),
        .byte_store (byte_store)
    );

    // One lane per byte of a host word, little-endian
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xfer_byte_lane #(.WORDS(WORDS), .WPTR_W(WPTR_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_we   (word_store),
            .host_addr (wptr),
            .host_byte (host_data_wdata[8*l +: 8]),
            .seq_we    (byte_store && (bptr[LANE_W-1:0] == LANE_W'(l))),
            .seq_addr  (bptr[BPTR_W-1:LANE_W]),
            .seq_byte  (seq_wdata),
            .host_q    (host_data_rdata[8*l +: 8]),
            .seq_q     (lane_seq_q[l])
        );
    end

    assign seq_rdata = lane_seq_q[bptr[LANE_W-1:0]];
endmodule

// File: rtl/xfer_word_window_chk.sv
// Module: checker for the pointer rules of the word-window buffer.
// Observes ports and pointer state only.
module xfer_word_window_chk #(
    parameter int WPTR_W = 7,
    parameter int BPTR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ctrl_we,
    input logic              host_data_we,
    input logic              host_data_re,
    input logic              host_stall,
    input logic              seq_active,
    input logic              seq_off_we,
    input logic              seq_rd,
    input logic              seq_wr,
    input logic              dir,
    input logic              autoinc,
    input logic [WPTR_W-1:0] wptr,
    input logic [BPTR_W-1:0] bptr
);
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && !host_ctrl_we) |=> $stable(wptr));

    p_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ctrl_we && !autoinc) |=> $stable(wptr));

    p_dir_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ctrl_we && dir && !host_data_we) |=> $stable(wptr));

    p_word_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ctrl_we && !seq_active && dir && host_data_we && autoinc
         && (wptr == {WPTR_W{1'b1}})) |=> (wptr == '0));

    p_byte_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && (seq_rd || seq_wr) && !seq_off_we
         && (bptr == {BPTR_W{1'b1}})) |=> (bptr == '0));

    p_seq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active && !seq_off_we) |=> $stable(bptr));
endmodule

bind xfer_word_window xfer_word_window_chk #(.WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ctrl_we (host_ctrl_we),
    .host_data_we (host_data_we),
    .host_data_re (host_data_re),
    .host_stall   (host_stall),
    .seq_active   (seq_active),
    .seq_off_we   (seq_off_we),
    .seq_rd       (seq_rd),
    .seq_wr       (seq_wr),
    .dir          (dir),
    .autoinc      (autoinc),
    .wptr         (wptr),
    .bptr         (bptr)
);

// File: tb/test_xfer_word_window.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a byte-level model of the store kept in the bench.
module test_xfer_word_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_we = 1'b0;
    logic [31:0] c_wd = '0;
    logic        d_we = 1'b0;
    logic [31:0] d_wd = '0;
    logic        d_re = 1'b0;
    logic [31:0] d_rd;
    logic        stall;
    logic        s_act = 1'b0;
    logic        o_we = 1'b0;
    logic [8:0]  o_val = '0;
    logic        s_rd = 1'b0;
    logic        s_wr = 1'b0;
    logic [7:0]  s_wd = '0;
    logic [7:0]  s_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdat [512];
    bit         mdir;
    bit         mai;
    int         mwp;
    int         mbp;

    always #4 clk = ~clk;   // 125 MHz

    xfer_word_window i_xfer_word_window (
        .clk (clk), .rst_n (rst_n),
        .host_ctrl_we (c_we), .host_ctrl_wdata (c_wd),
        .host_data_we (d_we), .host_data_wdata (d_wd),
        .host_data_re (d_re), .host_data_rdata (d_rd),
        .host_stall (stall), .seq_active (s_act),
        .seq_off_we (o_we), .seq_off (o_val),
        .seq_rd (s_rd), .seq_wr (s_wr),
        .seq_wdata (s_wd), .seq_rdata (s_q)
    );

    function automatic logic [31:0] mword(input int p);
        return {mdat[4*p+3], mdat[4*p+2], mdat[4*p+1], mdat[4*p]};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs that are applied now
    task automatic model_step();
        if (c_we) begin
            mdir = c_wd[31];
            mai  = c_wd[30];
            mwp  = int'(c_wd[6:0]);
        end else if (!(s_act && (d_re || d_we))) begin
            bit acc = mdir ? d_we : d_re;
            if (mdir && d_we)
                for (int k = 0; k < 4; k++) mdat[4*mwp+k] = d_wd[8*k +: 8];
            if (acc && mai) mwp = (mwp + 1) % 128;
        end
        if (o_we) begin
            mbp = int'(o_val);
        end else if (s_act && (s_rd || s_wr)) begin
            if (s_wr) mdat[mbp] = s_wd;
            mbp = (mbp + 1) % 512;
        end
    endtask

    // One cycle: inputs are already driven after a falling edge
    task automatic tick(input string tag);
        #1;
        chk(tag, "host_stall", {31'b0, stall}, {31'b0, s_act && (d_re || d_we)});
        @(posedge clk);
        model_step();
        #1;
        c_we = 0; d_we = 0; d_re = 0; o_we = 0; s_rd = 0; s_wr = 0; s_act = 0;
        chk(tag, "host window", d_rd, mword(mwp));
        chk(tag, "seq byte", {24'b0, s_q}, {24'b0, mdat[mbp]});
        @(negedge clk);
    endtask

    task automatic ctrl(input bit dirw, input bit ai, input logic [7:0] p, input string tag);
        c_we = 1; c_wd = {dirw, ai, 22'h2A5A5A, p};
        tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int unsigned seed = 32'h5EED_0017;
        void'($urandom(seed));
        for (int i = 0; i < 512; i++) mdat[i] = 8'h00;
        mdir = 0; mai = 0; mwp = 0; mbp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1 reset");

        // R2: direction, advance and pointer bit 7 ignored
        ctrl(1, 1, 8'h85, "R2 ctrl load");
        d_we = 1; d_wd = 32'h4433_2211; tick("R3 word store");
        o_we = 1; o_val = 9'd20; tick("R8 offset load");
        s_act = 1; s_rd = 1; tick("R9 little-endian byte");
        s_act = 1; s_rd = 1; tick("R9 byte advance");

        // R2: control write wins over a data write in the same cycle
        c_we = 1; c_wd = 32'hC000_0002; d_we = 1; d_wd = 32'hBAD0_BAD0;
        tick("R2 same-cycle drop");

        // R5: word pointer wrap
        ctrl(1, 1, 8'd127, "R5 pointer 127");
        d_we = 1; d_wd = 32'hDEAD_BEEF; tick("R5 wrap to 0");
        ctrl(0, 0, 8'd127, "R4 read back");
        d_re = 1; tick("R6 read no advance");

        // R6: repeated writes hit the same word
        ctrl(1, 0, 8'd3, "R6 setup");
        d_we = 1; d_wd = 32'h1111_1111; tick("R6 first write");
        d_we = 1; d_wd = 32'h2222_2222; tick("R6 same word");

        // R7: wrong-direction strobes
        ctrl(0, 1, 8'd3, "R7 setup");
        d_we = 1; d_wd = 32'h7777_7777; tick("R7 write ignored");
        ctrl(1, 1, 8'd3, "R7 setup write dir");
        d_re = 1; tick("R7 read no advance");

        // R11: host locked out during a transaction
        s_act = 1; d_we = 1; d_wd = 32'h5555_5555; tick("R11 stalled write");
        s_act = 1; d_re = 1; tick("R11 stalled read");

        // R10: byte wrap and idle strobes
        o_we = 1; o_val = 9'd511; tick("R8 offset 511");
        s_act = 1; s_wr = 1; s_wd = 8'h5A; tick("R10 byte wrap");
        s_wr = 1; s_wd = 8'hC3; tick("R10 idle write ignored");
        s_act = 1; s_rd = 1; o_we = 1; o_val = 9'd8; tick("R8 offset beats strobe");

        // R12: partial last word keeps its upper bytes
        ctrl(1, 1, 8'd0, "R12 setup");
        d_we = 1; d_wd = 32'hFFFF_FFFF; tick("R12 fill 0");
        d_we = 1; d_wd = 32'hFFFF_FFFF; tick("R12 fill 1");
        o_we = 1; o_val = 9'd0; tick("R12 offset 0");
        for (int b = 1; b <= 5; b++) begin
            s_act = 1; s_wr = 1; s_wd = 8'(b); tick("R12 seq byte");
        end
        ctrl(0, 0, 8'd1, "R12 partial word");
        chk("R12", "word 1", d_rd, 32'hFFFF_FF05);

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            c_we  = ($urandom % 100) < 6;
            c_wd  = $urandom;
            d_we  = $urandom % 2;
            d_re  = $urandom % 2;
            d_wd  = $urandom;
            s_act = ($urandom % 4) == 0;
            o_we  = ($urandom % 25) == 0;
            o_val = 9'($urandom);
            s_rd  = $urandom % 2;
            s_wr  = $urandom % 2;
            s_wd  = 8'($urandom);
            tick("RND R3 R4 R9 R10 R11");
        end
        finish_run();
    end
endmodule